// File: doc/BRIEF.md
# Ultra DMA burst timing engine

This block is the host-side sequencer for synchronous DMA bursts on a parallel disk interface. Four device slots each hold their own timing set: an enable, a base-clock rate select, a cycle time and a ready-to-pause delay. The cycle time and the delay are both counted in base-clock periods. The base clock is a clock-enable tick derived from the system clock. A start request names a device, a direction and a word count. The block takes the timing of that device when it accepts the request and then runs the burst on its own.

On a write burst the block drives a 16-bit data bus and toggles its strobe. Each strobe transition, rising or falling, hands over one word. Each word is placed on the bus well before the edge that carries it. If the device withdraws its ready line, the block holds the strobe level until ready returns. On a read burst the device drives the strobe. Both edges are synchronized and each one pushes the synchronized data word into a capture FIFO. When the word count runs out, the block drops its own ready line, waits the programmed pause delay and raises STOP.

Top module: `udma_burst_engine`

## Requirements
- R1: After reset, stop is 1 and host_ready, busy, done and rd_valid are all 0.
- R2: A start pulse is accepted only when the block is idle, the named device's enable bit is 1 and start_words is non-zero. In every other case busy stays 0, stop stays 1 and the burst in progress (if any) is unaffected. An accepted start samples that device's timing, and busy and a low stop appear in the cycle after it.
- R3: The base-clock tick period is 2^clksel system clock cycles (clksel 0..3 gives 1, 2, 4 or 8 cycles).
- R4: A write burst of N words makes exactly N transitions of host_strobe. At each transition ata_dout carries the next word in the order in which wr_take took words from wr_data. The first word is taken in the cycle the start is accepted.
- R5: With dev_ready held high, the first strobe transition comes exactly max(ct,1)*2^clksel cycles after acceptance. Each later one comes max(ct,1)*2^clksel+1 cycles after the one before. ata_dout last changes at least 2^clksel cycles before each transition.
- R6: If dev_ready has been low for 3 or more cycles, host_strobe does not change. Strobing resumes after dev_ready returns high.
- R7: At the end of a write burst, stop rises, busy falls and done pulses for one cycle, all exactly one cycle after the last strobe transition.
- R8: During a read burst every transition of dev_strobe, rising or falling, pushes the ata_din value present with it into the FIFO, in arrival order.
- R9: After the Nth read word is captured, host_ready falls. stop rises exactly rp*2^clksel+1 cycles after that, with a one-cycle done pulse, and busy falls in the same cycle.
- R10: rd_valid is 1 while the FIFO holds data. rd_data shows the oldest word, and rd_pop removes it.
- R11: While a read burst is collecting words, host_ready is 1 and stop is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the timing set of one device |
| cfg_drive | input | 2 | Device slot being written |
| cfg_enable | input | 1 | Synchronous DMA enable for that slot |
| cfg_clksel | input | 2 | Base-clock rate select (tick every 2^value cycles) |
| cfg_ct | input | 4 | Cycle time in base-clock periods (0 acts as 1) |
| cfg_rp | input | 4 | Ready-to-pause delay in base-clock periods |
| start | input | 1 | Burst request pulse |
| start_drive | input | 2 | Device slot for the burst |
| start_write | input | 1 | 1 for a write burst, 0 for a read burst |
| start_words | input | 16 | Number of 16-bit words in the burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| wr_data | input | 16 | Next word to write |
| wr_take | output | 1 | wr_data is taken at the coming clock edge |
| ata_dout | output | 16 | Write data bus |
| host_strobe | output | 1 | Host write strobe, both edges carry data |
| dev_ready | input | 1 | Device ready during writes (asynchronous) |
| host_ready | output | 1 | Host ready during reads |
| stop | output | 1 | STOP, high whenever no burst runs |
| dev_strobe | input | 1 | Device read strobe (asynchronous) |
| ata_din | input | 16 | Read data bus |
| rd_valid | output | 1 | Capture FIFO not empty |
| rd_data | output | 16 | Oldest captured word |
| rd_pop | input | 1 | Remove the oldest captured word |

## Verification
Write bursts are driven with every base-clock select and with cycle times from 0 to 15. The exact spacing of the strobe edges separates a wrong tick divider from a wrong cycle-time count and from a missing clamp of zero. Some write bursts have dev_ready withdrawn in the middle, which shows whether the strobe level is really held. Read bursts use pause delays from 0 up to 15 at different rates, and their captured contents show whether both strobe edges are taken in order. Starts on a disabled slot, with a zero count or during a busy burst show that such requests are dropped.

// File: rtl/udma_pkg.sv
package udma_pkg;
  localparam int TIME_W = 4;
  localparam int SEL_W  = 2;
  localparam int DIV_W  = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] clksel;
    logic [TIME_W-1:0] ct;
    logic [TIME_W-1:0] rp;
  } drv_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_W_WAIT, S_W_LOAD, S_W_FIN, S_R_RUN, S_R_PAUSE
  } seq_state_t;

  // system clock cycles per base-clock tick
  function automatic int unsigned tick_div(input logic [SEL_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // a zero cycle time is treated as one period
  function automatic logic [TIME_W-1:0] eff_ct(input logic [TIME_W-1:0] ct);
    return (ct == '0) ? TIME_W'(1) : ct;
  endfunction
endpackage

// File: rtl/udma_tick_gen.sv
module udma_tick_gen
  import udma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  always_comb last = DIV_W'(tick_div(sel) - 32'd1);
  assign tick = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + DIV_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && sel != '0) |=> !tick); // R3
endmodule

// File: rtl/udma_rd_capture.sv
module udma_rd_capture #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dev_strobe,
  input  logic [DATA_W-1:0] din,
  output logic              push,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [2:0]        stb_q;
  logic [DATA_W-1:0] d1, d2;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic              full, do_push, do_pop, edge_seen;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      d1    <= '0;
      d2    <= '0;
    end else begin
      stb_q <= {stb_q[1:0], dev_strobe};
      d1    <= din;
      d2    <= d1;
    end
  end

  assign edge_seen = stb_q[2] ^ stb_q[1];
  assign push      = edge_seen & en;
  assign full      = (32'(count) == DEPTH);
  assign do_push   = push & ~full;
  assign do_pop    = pop & (count != '0);
  assign valid     = (count != '0);
  assign dout      = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= d2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_EDGE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stb_q[2] != stb_q[1] && !full) |=> valid); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R10
endmodule

// File: rtl/udma_seq.sv
module udma_seq
  import udma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [CNT_W-1:0]  start_words,
  input  drv_cfg_t          start_cfg,
  input  logic              tick,
  output logic              tick_clr,
  output logic [SEL_W-1:0]  sel_q,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  output logic [DATA_W-1:0] dout,
  output logic              host_strobe,
  input  logic              dev_ready,
  output logic              host_ready,
  output logic              stop,
  input  logic              cap_push,
  output logic              cap_en,
  output logic              busy,
  output logic              done
);
  seq_state_t        state;
  logic [CNT_W-1:0]  words_left;
  logic [TIME_W-1:0] ct_q, rp_q, ct_left, rp_left;
  logic [1:0]        rdy_q;
  logic              rdy_s, accept, toggle_now, last_push;

  assign rdy_s      = rdy_q[1];
  assign accept     = start && (state == S_IDLE) && start_cfg.en && (start_words != '0);
  assign toggle_now = (state == S_W_WAIT) && tick && (ct_left <= TIME_W'(1)) && rdy_s;
  assign last_push  = (state == S_R_RUN) && cap_push && (words_left == CNT_W'(1));
  assign tick_clr   = accept || (state == S_W_LOAD) || last_push;
  assign wr_take    = (accept && start_write) || (state == S_W_LOAD);
  assign busy       = (state != S_IDLE);
  assign cap_en     = (state == S_R_RUN) || (state == S_R_PAUSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '0;
    else        rdy_q <= {rdy_q[0], dev_ready};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      words_left  <= '0;
      ct_q        <= '0;
      rp_q        <= '0;
      ct_left     <= '0;
      rp_left     <= '0;
      sel_q       <= '0;
      dout        <= '0;
      host_strobe <= 1'b0;
      host_ready  <= 1'b0;
      stop        <= 1'b1;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          words_left <= start_words;
          ct_q       <= eff_ct(start_cfg.ct);
          rp_q       <= start_cfg.rp;
          sel_q      <= start_cfg.clksel;
          stop       <= 1'b0;
          if (start_write) begin
            dout    <= wr_data;
            ct_left <= eff_ct(start_cfg.ct);
            state   <= S_W_WAIT;
          end else begin
            host_ready <= 1'b1;
            state      <= S_R_RUN;
          end
        end
        S_W_WAIT: if (tick) begin
          if (ct_left > TIME_W'(1)) begin
            ct_left <= ct_left - TIME_W'(1);
          end else if (rdy_s) begin
            host_strobe <= ~host_strobe;
            words_left  <= words_left - CNT_W'(1);
            state       <= (words_left == CNT_W'(1)) ? S_W_FIN : S_W_LOAD;
          end
        end
        S_W_LOAD: begin
          dout    <= wr_data;
          ct_left <= ct_q;
          state   <= S_W_WAIT;
        end
        S_W_FIN: begin
          stop  <= 1'b1;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_R_RUN: if (cap_push) begin
          words_left <= words_left - CNT_W'(1);
          if (words_left == CNT_W'(1)) begin
            host_ready <= 1'b0;
            rp_left    <= rp_q;
            state      <= S_R_PAUSE;
          end
        end
        S_R_PAUSE: begin
          if (rp_left == '0) begin
            stop  <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (tick) begin
            rp_left <= rp_left - TIME_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // cycles since the last strobe transition or burst acceptance
  logic [15:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_cnt <= '0;
    else if (accept || toggle_now)  gap_cnt <= '0;
    else if (gap_cnt != 16'hFFFF)   gap_cnt <= gap_cnt + 16'd1;
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe != $past(host_strobe)) |-> (32'($past(gap_cnt)) + 32'd1 >= 32'(ct_q) * tick_div(sel_q))); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe != $past(host_strobe)) |-> $stable(dout)); // R5
  AST_HOLD_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_ready && !$past(dev_ready) && !$past(dev_ready, 2)) |=> $stable(host_strobe)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> stop); // R2
  AST_PAUSE_BEFORE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ready) |-> !stop); // R9
  AST_READ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_R_RUN) |-> (host_ready && !stop)); // R11
endmodule

// File: rtl/udma_burst_engine.sv
module udma_burst_engine
  import udma_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int DRIVES     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DRV_W      = $clog2(DRIVES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DRV_W-1:0]  cfg_drive,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_clksel,
  input  logic [3:0]        cfg_ct,
  input  logic [3:0]        cfg_rp,
  input  logic              start,
  input  logic [DRV_W-1:0]  start_drive,
  input  logic              start_write,
  input  logic [CNT_W-1:0]  start_words,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  output logic [DATA_W-1:0] ata_dout,
  output logic              host_strobe,
  input  logic              dev_ready,
  output logic              host_ready,
  output logic              stop,
  input  logic              dev_strobe,
  input  logic [DATA_W-1:0] ata_din,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_pop
);
  drv_cfg_t         cfg_q [DRIVES];
  drv_cfg_t         sel_cfg;
  logic [DRIVES-1:0] cfg_hit;
  logic             tick, tick_clr, cap_push, cap_en;
  logic [SEL_W-1:0] sel_q;

  for (genvar g = 0; g < DRIVES; g++) begin : g_hit
    assign cfg_hit[g] = cfg_we && (32'(cfg_drive) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DRIVES; i++) cfg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DRIVES; i++)
        if (cfg_hit[i]) cfg_q[i] <= '{en: cfg_enable, clksel: cfg_clksel, ct: cfg_ct, rp: cfg_rp};
    end
  end

  assign sel_cfg = cfg_q[start_drive];

  udma_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .sel(sel_q), .tick(tick)
  );

  udma_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_write(start_write), .start_words(start_words), .start_cfg(sel_cfg),
    .tick(tick), .tick_clr(tick_clr), .sel_q(sel_q),
    .wr_data(wr_data), .wr_take(wr_take), .dout(ata_dout), .host_strobe(host_strobe),
    .dev_ready(dev_ready), .host_ready(host_ready), .stop(stop),
    .cap_push(cap_push), .cap_en(cap_en), .busy(busy), .done(done)
  );

  udma_rd_capture #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .dev_strobe(dev_strobe), .din(ata_din),
    .push(cap_push), .pop(rd_pop), .valid(rd_valid), .dout(rd_data)
  );
endmodule

// File: tb/udma_burst_engine_test.sv
`timescale 1ns/1ps
module udma_burst_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_enable = 0, start = 0, start_write = 0;
  logic [1:0] cfg_drive = 0, cfg_clksel = 0, start_drive = 0;
  logic [3:0] cfg_ct = 0, cfg_rp = 0;
  logic [15:0] start_words = 0, wr_data = 0, ata_din = 0;
  logic dev_ready = 1, dev_strobe = 0, rd_pop = 0;
  logic busy, done, wr_take, host_strobe, host_ready, stop, rd_valid;
  logic [15:0] ata_dout, rd_data;

  udma_burst_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_drive(cfg_drive), .cfg_enable(cfg_enable),
    .cfg_clksel(cfg_clksel), .cfg_ct(cfg_ct), .cfg_rp(cfg_rp), .start(start),
    .start_drive(start_drive), .start_write(start_write), .start_words(start_words),
    .busy(busy), .done(done), .wr_data(wr_data), .wr_take(wr_take), .ata_dout(ata_dout),
    .host_strobe(host_strobe), .dev_ready(dev_ready), .host_ready(host_ready), .stop(stop),
    .dev_strobe(dev_strobe), .ata_din(ata_din), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_pop(rd_pop)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit b_en [4];
  int b_sel [4], b_ct [4], b_rp [4];

  // expectation state
  int n_tog, last_tog, acc_cyc, dout_chg, stop_rise, hrdy_fall, done_cyc, done_cnt;
  int cur_ct, cur_div, rdy_low_cyc, wr_idx;
  bit rdy_low, pause_mode;
  logic [15:0] wr_base;
  logic prev_stb, prev_busy, prev_stop, prev_hrdy;
  logic [15:0] prev_dout;

  function automatic int exp_div(int sel); return 1 << sel; endfunction
  function automatic int exp_ct(int ct); return (ct == 0) ? 1 : ct; endfunction
  function automatic logic [15:0] pat(logic [15:0] b, int i);
    return b ^ 16'(i * 40503 + 257);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // supply write words: wr_take means wr_data is taken at the next edge
  always @(negedge clk) begin
    #2;
    if (wr_take) begin
      @(posedge clk);
      #1;
      wr_idx++;
      wr_data = pat(wr_base, wr_idx);
    end
  end

  // port monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) acc_cyc = cyc;
      if (ata_dout != prev_dout) dout_chg = cyc;
      if (host_strobe != prev_stb) begin
        chk(ata_dout == pat(wr_base, n_tog), "R4 word order", int'(ata_dout), int'(pat(wr_base, n_tog)));
        if (n_tog == 0)
          chk(cyc - acc_cyc == cur_ct * cur_div, "R5 first edge", cyc - acc_cyc, cur_ct * cur_div);
        else if (!pause_mode)
          chk(cyc - last_tog == cur_ct * cur_div + 1, "R3 R5 edge spacing", cyc - last_tog, cur_ct * cur_div + 1);
        else
          chk(cyc - last_tog >= cur_ct * cur_div + 1, "R5 min spacing", cyc - last_tog, cur_ct * cur_div + 1);
        chk(cyc - dout_chg >= cur_div, "R5 data setup", cyc - dout_chg, cur_div);
        if (rdy_low) chk(cyc < rdy_low_cyc + 3, "R6 held while not ready", cyc - rdy_low_cyc, 2);
        n_tog++;
        last_tog = cyc;
      end
      if (stop && !prev_stop) stop_rise = cyc;
      if (!host_ready && prev_hrdy) hrdy_fall = cyc;
      if (done) begin done_cyc = cyc; done_cnt++; end
    end
    prev_stb = host_strobe; prev_busy = busy; prev_stop = stop;
    prev_hrdy = host_ready; prev_dout = ata_dout;
  end

  task automatic cfg_write(int d, bit en, int sel, int ct, int rp);
    @(negedge clk);
    cfg_we = 1; cfg_drive = 2'(d); cfg_enable = en;
    cfg_clksel = 2'(sel); cfg_ct = 4'(ct); cfg_rp = 4'(rp);
    @(negedge clk);
    cfg_we = 0;
    b_en[d] = en; b_sel[d] = sel; b_ct[d] = ct; b_rp[d] = rp;
  endtask

  task automatic pulse_start(int d, bit wr, int n);
    @(negedge clk);
    start = 1; start_drive = 2'(d); start_write = wr; start_words = 16'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic do_write(int d, int n, bit with_pause, bit busy_start);
    int d0;
    cur_ct = exp_ct(b_ct[d]); cur_div = exp_div(b_sel[d]);
    wr_base = 16'($urandom); wr_idx = 0; wr_data = pat(wr_base, 0);
    n_tog = 0; pause_mode = with_pause; d0 = done_cnt;
    pulse_start(d, 1'b1, n);
    chk(busy == 1 && stop == 0, "R2 accepted write", int'({busy, stop}), 2);
    if (busy_start) pulse_start((d + 1) % 4, 1'b0, 3);
    if (with_pause) begin
      while (n_tog < 2) @(negedge clk);
      dev_ready = 0; rdy_low = 1; rdy_low_cyc = cyc;
      repeat (20) @(negedge clk);
      dev_ready = 1; rdy_low = 0;
    end
    wait_done(d0);
    chk(n_tog == n, "R4 edge count", n_tog, n);
    chk(stop_rise == last_tog + 1, "R7 stop after last edge", stop_rise - last_tog, 1);
    chk(done_cyc == last_tog + 1, "R7 done pulse", done_cyc - last_tog, 1);
    chk(busy == 0, "R7 busy clear", busy, 0);
    @(negedge clk);
    chk(done == 0, "R7 done single", done, 0);
  endtask

  task automatic do_read(int d, int n);
    int d0;
    logic [15:0] base;
    base = 16'($urandom); d0 = done_cnt;
    pulse_start(d, 1'b0, n);
    chk(busy == 1 && stop == 0, "R2 accepted read", int'({busy, stop}), 2);
    for (int i = 0; i < n; i++) begin
      chk(host_ready == 1 && stop == 0, "R11 ready while collecting", int'({host_ready, stop}), 2);
      ata_din = pat(base, i);
      @(negedge clk);
      dev_strobe = ~dev_strobe;
      repeat (6) @(negedge clk);
    end
    wait_done(d0);
    chk(stop_rise - hrdy_fall == b_rp[d] * exp_div(b_sel[d]) + 1, "R9 pause delay",
        stop_rise - hrdy_fall, b_rp[d] * exp_div(b_sel[d]) + 1);
    chk(done_cyc == stop_rise && busy == 0, "R9 done with stop", done_cyc - stop_rise, 0);
    for (int i = 0; i < n; i++) begin
      chk(rd_valid == 1, "R10 valid", rd_valid, 1);
      chk(rd_data == pat(base, i), "R8 captured word", int'(rd_data), int'(pat(base, i)));
      rd_pop = 1;
      @(negedge clk);
      rd_pop = 0;
    end
    chk(rd_valid == 0, "R10 drained", rd_valid, 0);
  endtask

  task automatic ignored_start(int d, bit wr, int n, string why);
    pulse_start(d, wr, n);
    repeat (4) begin
      chk(busy == 0 && stop == 1, why, int'({busy, stop}), 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(stop == 1, "R1 stop", stop, 1);
    chk(host_ready == 0 && busy == 0 && done == 0, "R1 idle", int'({host_ready, busy, done}), 0);
    chk(rd_valid == 0, "R1 fifo empty", rd_valid, 0);

    // R2: disabled slot and zero count are dropped
    ignored_start(0, 1'b1, 4, "R2 disabled drive");
    cfg_write(0, 1, 0, 3, 2);
    ignored_start(0, 1'b1, 0, "R2 zero words");

    // fastest setting: tick every clock, cycle time 3
    do_write(0, 6, 0, 0);
    // zero cycle time acts as one, divider 2; a start while busy is dropped
    cfg_write(1, 1, 1, 0, 0);
    do_write(1, 5, 0, 1);
    // device withdraws ready mid-burst (R6)
    cfg_write(2, 1, 2, 2, 1);
    do_write(2, 8, 1, 0);
    // reads: zero pause, and a longer pause at a slower rate
    cfg_write(3, 1, 0, 1, 0);
    do_read(3, 4);
    cfg_write(3, 1, 2, 1, 5);
    do_read(3, 8);
    cfg_write(1, 1, 3, 15, 15);
    do_read(1, 2);

    for (int k = 0; k < 12; k++) begin
      int d;
      d = $urandom_range(0, 3);
      cfg_write(d, 1, $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) do_write(d, $urandom_range(1, 10), 0, 0);
      else                           do_read(d, $urandom_range(1, 8));
    end
    summary();
  end
endmodule